// File: doc/BRIEF.md
# Single-Cycle Integer Core for a Six-Instruction Subset

This block is a small processor core that finishes every instruction in one clock. It supports register add and subtract, word load, word store, branch-if-equal and an unconditional jump. The core fetches one instruction word per cycle through a read-only instruction port. A separate data port carries loads and stores. All decode, register reads, arithmetic, memory access and register write-back happen inside that one cycle, and the program counter and register file update on the rising edge that closes it.

The core is meant to be placed next to two simple memories with combinational reads: one holds the program and one holds the data. The data memory takes its write on the clock edge. The ALU operation comes from two stages. A main decoder classifies the opcode, and a second stage resolves R-type instructions from their function field. Branch and jump targets are formed from the incremented program counter.

Top module: `sc_core`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it falls, `imem_addr` equals `RESET_PC` (default 0). No data write is issued during reset.
- R2: An instruction that is neither a taken branch nor a jump is followed by a fetch from the current address plus 4.
- R3: An R-type instruction (bits 31:26 = 0x00) with function field (bits 5:0) 0x20 writes the sum of registers rs (bits 25:21) and rt (bits 20:16) to register rd (bits 15:11). Register rt is left unchanged.
- R4: An R-type instruction with function field 0x22 writes rs minus rt, modulo 2^32, to rd.
- R5: Opcode 0x23 (load) writes the data word at address rs + sign-extended bits 15:0 to register rt.
- R6: Opcode 0x2B (store) drives `dmem_we` high, puts rs + sign-extended bits 15:0 on `dmem_addr` and puts register rt on `dmem_wdata`. This includes negative offsets.
- R7: Opcode 0x04 (branch-if-equal) with equal rs and rt makes the next fetch address (PC+4) + 4 × sign-extended bits 15:0. Backward offsets are included.
- R8: A branch-if-equal whose rs and rt differ continues at PC+4.
- R9: Opcode 0x02 (jump) makes the next fetch address {PC+4 bits 31:28, instruction bits 25:0, 2'b00}.
- R10: Register 0 always reads as zero, and writes to it have no effect.
- R11: `dmem_re` is high only for a load and `dmem_we` is high only for a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at `imem_addr` (combinational read) |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken at the rising edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at `dmem_addr` (combinational read) |

## Verification
The bench builds the core with the default values: 32 registers, a reset address of 0, and the shared add/subtract adder. With a 32-entry file, every register field in the test program names its own storage element. A reset address of 0 lets the program start at the bottom of the bench memory. The shared-adder variant exercises the inverted-operand carry-in path for both subtraction and the beq equality test. The program covers a forward taken branch, a not-taken branch, a backward self-loop, a jump, a negative store offset and a write aimed at register 0.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_J     = 6'h02;

   localparam logic [5:0] FN_ADD   = 6'h20;
   localparam logic [5:0] FN_SUB   = 6'h22;

   // class chosen by the main decoder; AC_FUNCT defers to the function field
   typedef enum logic [1:0] {
      AC_ADD   = 2'd0,
      AC_SUB   = 2'd1,
      AC_FUNCT = 2'd2
   } alu_class_e;

   typedef enum logic {
      ALU_ADD = 1'b0,
      ALU_SUB = 1'b1
   } alu_op_e;

   typedef struct packed {
      logic       sel_rd;      // write target: rd when set, rt otherwise
      logic       sel_imm;     // ALU operand B: immediate when set
      logic       sel_mem;     // write-back source: load data when set
      logic       rf_wen;
      logic       mem_rd;
      logic       mem_wr;
      logic       is_branch;
      logic       is_jump;
      alu_class_e alu_class;
   } ctrl_t;

endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int XLEN    = 32,
   parameter int REG_NUM = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wen,
   input  logic [4:0]      raddr_a,
   input  logic [4:0]      raddr_b,
   input  logic [4:0]      waddr,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] rdata_a,
   output logic [XLEN-1:0] rdata_b
);
   localparam int RA_W = $clog2(REG_NUM);

   logic [XLEN-1:0] regs [REG_NUM];
   logic [RA_W-1:0] ra_i, rb_i, wa_i;

   assign ra_i = raddr_a[RA_W-1:0];
   assign rb_i = raddr_b[RA_W-1:0];
   assign wa_i = waddr[RA_W-1:0];

   // entry 0 is cleared by reset and never written afterwards
   always_ff @(posedge clk) begin
      for (int i = 0; i < REG_NUM; i++) begin
         if (rst)
            regs[i] <= '0;
         else if (wen && (i != 0) && (wa_i == RA_W'(i)))
            regs[i] <= wdata;
      end
   end

   assign rdata_a = regs[ra_i];
   assign rdata_b = regs[rb_i];

   // R10: an index of zero on the write port never disturbs register 0
   assert_r0_hold_R10 : assert property (@(posedge clk) disable iff (rst)
      (wen && wa_i == '0) |=> (regs[0] == '0));

endmodule

// File: rtl/sc_alu.sv
module sc_alu #(
   parameter int XLEN         = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  sc_pkg::alu_op_e op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y,
   output logic            zero
);
   import sc_pkg::*;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [XLEN-1:0] b_eff;
         logic [XLEN-1:0] cin;
         assign b_eff = (op == ALU_SUB) ? ~b : b;
         assign cin   = {{(XLEN-1){1'b0}}, (op == ALU_SUB)};
         assign y     = a + b_eff + cin;
      end else begin : g_split
         logic [XLEN-1:0] sum;
         logic [XLEN-1:0] diff;
         assign sum  = a + b;
         assign diff = a - b;
         assign y    = (op == ALU_SUB) ? diff : sum;
      end
   endgenerate

   assign zero = (y == '0);

endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl (
   input  logic [5:0]      opcode,
   input  logic [5:0]      funct,
   output sc_pkg::ctrl_t   ctrl,
   output sc_pkg::alu_op_e alu_op
);
   import sc_pkg::*;

   // stage 1: main decoder, opcode only
   always_comb begin
      ctrl = '0;
      ctrl.alu_class = AC_ADD;
      unique case (opcode)
         OP_RTYPE: begin
            ctrl.sel_rd    = 1'b1;
            ctrl.rf_wen    = 1'b1;
            ctrl.alu_class = AC_FUNCT;
         end
         OP_LW: begin
            ctrl.sel_imm = 1'b1;
            ctrl.sel_mem = 1'b1;
            ctrl.rf_wen  = 1'b1;
            ctrl.mem_rd  = 1'b1;
         end
         OP_SW: begin
            ctrl.sel_imm = 1'b1;
            ctrl.mem_wr  = 1'b1;
         end
         OP_BEQ: begin
            ctrl.is_branch = 1'b1;
            ctrl.alu_class = AC_SUB;
         end
         OP_J: begin
            ctrl.is_jump = 1'b1;
         end
         default: ;
      endcase
   end

   // stage 2: ALU control, class plus function field
   always_comb begin
      unique case (ctrl.alu_class)
         AC_SUB:   alu_op = ALU_SUB;
         AC_FUNCT: alu_op = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
         default:  alu_op = ALU_ADD;
      endcase
   end

endmodule

// File: rtl/sc_next_pc.sv
module sc_next_pc #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] imm_ext,
   input  logic [25:0]     jidx,
   input  logic            is_branch,
   input  logic            equal,
   input  logic            is_jump,
   output logic [XLEN-1:0] pc_plus4,
   output logic [XLEN-1:0] pc_next
);
   logic [XLEN-1:0] br_target;
   logic [XLEN-1:0] j_target;

   assign pc_plus4  = pc + XLEN'(4);
   assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
   assign j_target  = {pc_plus4[XLEN-1:28], jidx, 2'b00};

   always_comb begin
      if (is_jump)
         pc_next = j_target;
      else if (is_branch && equal)
         pc_next = br_target;
      else
         pc_next = pc_plus4;
   end

endmodule

// File: rtl/sc_core.sv
module sc_core #(
   parameter int          XLEN         = 32,
   parameter int          REG_NUM      = 32,
   parameter logic [31:0] RESET_PC     = 32'h0,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   output logic [31:0] imem_addr,
   input  logic [31:0] imem_rdata,
   output logic [31:0] dmem_addr,
   output logic [31:0] dmem_wdata,
   output logic        dmem_we,
   output logic        dmem_re,
   input  logic [31:0] dmem_rdata
);
   import sc_pkg::*;

   localparam int IMM_W = 16;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("sc_core: XLEN must be 32");
      end
      if (REG_NUM < 2 || REG_NUM > 32 || (REG_NUM & (REG_NUM - 1)) != 0) begin : g_bad_regs
         $error("sc_core: REG_NUM must be a power of two in 2..32");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_rpc
         $error("sc_core: RESET_PC must be word aligned");
      end
   endgenerate

   logic [XLEN-1:0] pc, pc_plus4, pc_next;
   logic [5:0]      f_op, f_fn;
   logic [4:0]      f_rs, f_rt, f_rd, wr_idx;
   logic [XLEN-1:0] imm_ext, rf_a, rf_b, alu_b, alu_y, wb_data;
   logic            alu_zero;
   ctrl_t           ctrl;
   alu_op_e         alu_op;

   assign f_op    = imem_rdata[31:26];
   assign f_rs    = imem_rdata[25:21];
   assign f_rt    = imem_rdata[20:16];
   assign f_rd    = imem_rdata[15:11];
   assign f_fn    = imem_rdata[5:0];
   assign imm_ext = {{(XLEN-IMM_W){imem_rdata[IMM_W-1]}}, imem_rdata[IMM_W-1:0]};

   always_ff @(posedge clk) begin
      if (rst) pc <= RESET_PC;
      else     pc <= pc_next;
   end

   sc_ctrl u_ctrl (
      .opcode (f_op),
      .funct  (f_fn),
      .ctrl   (ctrl),
      .alu_op (alu_op)
   );

   assign wr_idx  = ctrl.sel_rd ? f_rd : f_rt;
   assign wb_data = ctrl.sel_mem ? dmem_rdata : alu_y;

   sc_regfile #(.XLEN(XLEN), .REG_NUM(REG_NUM)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .wen     (ctrl.rf_wen),
      .raddr_a (f_rs),
      .raddr_b (f_rt),
      .waddr   (wr_idx),
      .wdata   (wb_data),
      .rdata_a (rf_a),
      .rdata_b (rf_b)
   );

   assign alu_b = ctrl.sel_imm ? imm_ext : rf_b;

   sc_alu #(.XLEN(XLEN), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .op   (alu_op),
      .a    (rf_a),
      .b    (alu_b),
      .y    (alu_y),
      .zero (alu_zero)
   );

   sc_next_pc #(.XLEN(XLEN)) u_npc (
      .pc        (pc),
      .imm_ext   (imm_ext),
      .jidx      (imem_rdata[25:0]),
      .is_branch (ctrl.is_branch),
      .equal     (alu_zero),
      .is_jump   (ctrl.is_jump),
      .pc_plus4  (pc_plus4),
      .pc_next   (pc_next)
   );

   assign imem_addr  = pc;
   assign dmem_addr  = alu_y;
   assign dmem_wdata = rf_b;
   assign dmem_we    = ctrl.mem_wr & ~rst;
   assign dmem_re    = ctrl.mem_rd & ~rst;

   // R11: memory strobes follow the fetched opcode
   assert_we_only_store_R11 : assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> (f_op == OP_SW));
   assert_re_only_load_R11 : assert property (@(posedge clk) disable iff (rst)
      dmem_re |-> (f_op == OP_LW));

   // R2: straight-line instructions advance by one word
   assert_seq_fetch_R2 : assert property (@(posedge clk) disable iff (rst)
      (f_op != OP_BEQ && f_op != OP_J) |=> (imem_addr == $past(imem_addr) + 32'd4));

   // R7 / R8: branch outcome follows register equality
   assert_beq_taken_R7 : assert property (@(posedge clk) disable iff (rst)
      (f_op == OP_BEQ && rf_a == rf_b)
      |=> (imem_addr == $past(pc_plus4) + ($past(imm_ext) << 2)));
   assert_beq_fall_R8 : assert property (@(posedge clk) disable iff (rst)
      (f_op == OP_BEQ && rf_a != rf_b) |=> (imem_addr == $past(imem_addr) + 32'd4));

   // R9: jump target keeps the upper nibble of PC+4
   assert_jump_target_R9 : assert property (@(posedge clk) disable iff (rst)
      (f_op == OP_J) |=> (imem_addr == {$past(pc_plus4[31:28]), $past(imem_rdata[25:0]), 2'b00}));

   // R10: reads of register 0 see zero
   assert_r0_reads_zero_R10 : assert property (@(posedge clk) disable iff (rst)
      (f_rs == 5'd0) |-> (rf_a == '0));

endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/100ps
module sc_core_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we, dmem_re;

   logic [31:0] imem [64];
   logic [31:0] dmem [64];

   int n_chk  = 0;
   int n_fail = 0;

   typedef struct {
      logic [31:0] pc;
      logic        re;
      string       tag;
   } fetch_t;

   typedef struct {
      logic [31:0] addr;
      logic [31:0] data;
      string       tag;
   } store_t;

   fetch_t exp_fetch [$];
   store_t exp_store [$];

   always #2.5 clk = ~clk;

   sc_core u_dut (
      .clk        (clk),
      .rst        (rst),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_re    (dmem_re),
      .dmem_rdata (dmem_rdata)
   );

   assign imem_rdata = imem[imem_addr[7:2]];
   assign dmem_rdata = dmem[dmem_addr[7:2]];

   always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

   function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction
   function automatic logic [31:0] enc_j(input logic [25:0] idx);
      return {6'h02, idx};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic expect_fetch(input logic [31:0] pc, input logic re, input string tag);
      fetch_t f;
      f.pc = pc; f.re = re; f.tag = tag;
      exp_fetch.push_back(f);
   endtask

   task automatic expect_store(input logic [31:0] a, input logic [31:0] d, input string tag);
      store_t s;
      s.addr = a; s.data = d; s.tag = tag;
      exp_store.push_back(s);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // monitor: compare the design against the scoreboard queues
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst) begin
            chk(imem_addr == 32'h0, "R1 reset pc", imem_addr, 32'h0);
            chk(dmem_we == 1'b0, "R1 no write in reset", 32'(dmem_we), 32'h0);
         end else begin
            if (exp_fetch.size() > 0) begin
               fetch_t f;
               f = exp_fetch.pop_front();
               chk(imem_addr == f.pc, f.tag, imem_addr, f.pc);
               chk(dmem_re == f.re, "R11 load strobe", 32'(dmem_re), 32'(f.re));
            end
            if (dmem_we) begin
               if (exp_store.size() == 0) begin
                  chk(1'b0, "R11 unexpected store", dmem_addr, 32'hFFFF_FFFF);
               end else begin
                  store_t s;
                  s = exp_store.pop_front();
                  chk(dmem_addr == s.addr, {s.tag, " addr"}, dmem_addr, s.addr);
                  chk(dmem_wdata == s.data, {s.tag, " data"}, dmem_wdata, s.data);
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      finish_run();
   end

   // driver: program, data and expected trace
   initial begin
      for (int i = 0; i < 64; i++) begin
         imem[i] = 32'h0;
         dmem[i] = 32'h0;
      end
      dmem[0] = 32'd5;
      dmem[1] = 32'd7;

      imem[0]  = enc_i(6'h23, 0, 1, 16'd0);        // lw  r1, 0(r0)
      imem[1]  = enc_i(6'h23, 0, 2, 16'd4);        // lw  r2, 4(r0)
      imem[2]  = enc_r(1, 2, 3, 6'h20);            // add r3 = r1 + r2
      imem[3]  = enc_r(1, 2, 4, 6'h22);            // sub r4 = r1 - r2
      imem[4]  = enc_i(6'h2B, 0, 3, 16'd16);       // sw  r3, 16(r0)
      imem[5]  = enc_i(6'h2B, 0, 4, 16'd20);       // sw  r4, 20(r0)
      imem[6]  = enc_r(1, 2, 0, 6'h20);            // add r0 = r1 + r2 (ignored)
      imem[7]  = enc_i(6'h2B, 0, 0, 16'd24);       // sw  r0, 24(r0)
      imem[8]  = enc_i(6'h04, 1, 2, 16'd5);        // beq r1, r2 (not taken)
      imem[9]  = enc_i(6'h2B, 0, 1, 16'd28);       // sw  r1, 28(r0)
      imem[10] = enc_i(6'h04, 1, 1, 16'd3);        // beq r1, r1 -> 0x38
      for (int i = 11; i < 14; i++)
         imem[i] = enc_i(6'h2B, 0, 2, 16'd32);     // skipped
      imem[14] = enc_i(6'h2B, 3, 2, 16'hFFFC);     // sw  r2, -4(r3) -> addr 8
      imem[15] = enc_j(26'h14);                    // j   0x50
      for (int i = 16; i < 20; i++)
         imem[i] = enc_i(6'h2B, 0, 1, 16'd36);     // skipped
      imem[20] = enc_i(6'h04, 0, 0, 16'hFFFF);     // beq r0, r0, -1 -> self

      expect_fetch(32'h00, 1'b1, "R1 first fetch");
      expect_fetch(32'h04, 1'b1, "R2 R5 after load");
      expect_fetch(32'h08, 1'b0, "R2");
      expect_fetch(32'h0C, 1'b0, "R2 after add");
      expect_fetch(32'h10, 1'b0, "R2 after sub");
      expect_fetch(32'h14, 1'b0, "R2 after store");
      expect_fetch(32'h18, 1'b0, "R2");
      expect_fetch(32'h1C, 1'b0, "R2");
      expect_fetch(32'h20, 1'b0, "R2");
      expect_fetch(32'h24, 1'b0, "R8 not taken");
      expect_fetch(32'h28, 1'b0, "R2");
      expect_fetch(32'h38, 1'b0, "R7 forward taken");
      expect_fetch(32'h3C, 1'b0, "R2");
      expect_fetch(32'h50, 1'b0, "R9 jump");
      expect_fetch(32'h50, 1'b0, "R7 backward taken");
      expect_fetch(32'h50, 1'b0, "R7 backward taken again");

      expect_store(32'd16, 32'd12,          "R3 add result");
      expect_store(32'd20, 32'hFFFF_FFFE,   "R4 sub result");
      expect_store(32'd24, 32'd0,           "R10 zero register");
      expect_store(32'd28, 32'd5,           "R5 loaded word");
      expect_store(32'd8,  32'd7,           "R6 negative offset");

      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (30) @(negedge clk);
      #2;

      chk(exp_fetch.size() == 0, "R2 fetch trace consumed", 32'(exp_fetch.size()), 32'h0);
      chk(exp_store.size() == 0, "R6 store trace consumed", 32'(exp_store.size()), 32'h0);
      chk(dmem[8] == 32'h0, "R7 skipped path untouched", dmem[8], 32'h0);
      chk(dmem[9] == 32'h0, "R9 skipped path untouched", dmem[9], 32'h0);
      chk(dmem[2] == 32'd7, "R3 rt unchanged by add", dmem[2], 32'd7);
      chk(dmem[6] == 32'h0, "R10 write to r0 ignored", dmem[6], 32'h0);
      finish_run();
   end

endmodule